// File: doc/BRIEF.md
# Token-Passing Hit Readout Sequencer

This block serves the channels of a multi-channel front end that have recorded a hit, one channel per cycle of a slow acquisition clock. The channels form a daisy chain fed by an active-low chip token. A channel whose hit flag is clear passes the token straight on to the next higher index. The first hit channel that the token reaches holds it. The rising edge of the acquisition clock makes that channel active. The falling edge clears its hit flag, so the token moves on to the next hit channel. The following rising edge drops the old active state and makes the next channel active, if one is waiting.

The acquisition clock is not used as a clock. It passes through a synchronizer on the system clock, and its rising and falling edges become single-cycle events. Hit flags are set from per-channel set pulses, and a load strobe can overwrite all of them at once, for example to re-arm a chosen set of channels. The outputs are a chip token out, an acknowledge that stays high while work remains, an OR of all hit flags, and a channel address on bidirectional lines. With internal addressing the block drives those lines. With external addressing it releases them and takes the address from outside.

A four-state machine tracks the phase. ST_IDLE means no hit and no active channel. ST_PEND means hits are waiting and no channel is active. ST_SERVE means a channel is active and its flag is still set. ST_RETIRE means the active channel's flag has been cleared and the next rising edge is awaited. The transitions are:
- IDLE->PEND and PEND->IDLE follow whether any flag is set.
- Any state goes to SERVE on a rising edge that grants a channel.
- Without a grant, a rising edge goes to PEND if flags remain and to IDLE if none remain.
- SERVE->RETIRE happens on a falling edge.

Top module: `tok_acq_seq`

## Requirements
- R1: On a synchronized rising edge of the acquisition clock, the active vector becomes one-hot on the lowest-index channel whose hit flag is set, provided the chip token in is low. It becomes all zero if there is no such channel. Any previously active channel is dropped on the same edge. At most one channel is ever active.
- R2: On a synchronized falling edge, the hit flag of the active channel is cleared. Other flags are not changed.
- R3: A channel passes a low token to the next one when its own token is low and its hit flag is clear. Channel 0 receives the chip token in. The chip token out is low exactly when token in is low and no hit flag is set.
- R4: The acknowledge output is high while any hit flag is set or any channel is active. It is low otherwise.
- R5: The any-hit output is the OR of all hit flags.
- R6: A high bit on the set input sets that channel's flag on the next system clock edge. When a set and a falling-edge clear hit the same channel in the same cycle, the set wins.
- R7: The load strobe replaces every hit flag with the load data on the next system clock edge. It overrides both set and clear.
- R8: With external addressing deselected, the address lines drive the following value, and the selected-address output shows the same value:
  - the index of the active channel, if one is active;
  - otherwise the lowest index with a hit flag set;
  - otherwise zero.
- R9: With external addressing selected, the address lines are high impedance, and the selected-address output follows the externally driven lines.
- R10: A rising edge while the chip token in is high activates no channel and leaves the hit flags unchanged.
- R11: After reset, all hit flags are clear, no channel is active, acknowledge and any-hit are low, and the chip token out equals the token in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acq_clk_i | input | 1 | Acquisition clock, sampled on clk |
| tok_in_n_i | input | 1 | Chip token in, active low |
| hit_set_i | input | NCH | Per-channel hit set pulses |
| hit_load_i | input | 1 | Strobe that overwrites all hit flags |
| hit_load_data_i | input | NCH | Values for the hit flags on a load |
| ext_addr_sel_i | input | 1 | High: address lines are inputs |
| addr_io | inout | AW | Channel address lines |
| tok_out_n_o | output | 1 | Chip token out, active low |
| ack_o | output | 1 | Acquisition in progress |
| any_hit_o | output | 1 | OR of all hit flags |
| sel_addr_o | output | AW | Address currently selected (internal or external) |

## Verification
The bench walks several hit patterns through the chain: a lone hit, adjacent hits, the highest channel only, and random patterns. It checks that each rising edge hands the token to the next hit channel. A design that skipped a channel, or that kept two channels active, would show a wrong address or an acknowledge that ends early. It raises the token in during a rising edge. It sets a flag in the same cycle as a falling edge on that channel, where a clear that won would lose the event. It loads flags in the middle of a readout, where ignoring the load would leave the token out stuck high. It also checks that acknowledge stays high from the last falling edge until the final rising edge, while the token out has already gone low. A design that tied acknowledge to the token would drop it one phase early.

// File: rtl/tok_acq_pkg.sv
package tok_acq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_PEND   = 2'd1,
        ST_SERVE  = 2'd2,
        ST_RETIRE = 2'd3
    } acq_state_e;

    // index of the lowest set bit of a vector, zero if none
    function automatic int unsigned lowest_set(input logic [63:0] vec, input int unsigned width);
        int unsigned idx;
        idx = 0;
        for (int i = int'(width) - 1; i >= 0; i--) begin
            if (vec[i]) idx = i;
        end
        return idx;
    endfunction

endpackage

// File: rtl/tok_acq_edge.sv
module tok_acq_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o,
    output logic fall_o
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_sync
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sync_q[0] <= 1'b0;
                    else        sync_q[0] <= async_i;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sync_q[s] <= 1'b0;
                    else        sync_q[s] <= sync_q[s-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sync_q[STAGES-1];
    end

    assign rise_o = sync_q[STAGES-1] & ~prev_q;
    assign fall_o = ~sync_q[STAGES-1] & prev_q;

    a_r1_edges_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(rise_o && fall_o));
    a_r1_no_double_rise: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);
endmodule

// File: rtl/tok_acq_hits.sv
module tok_acq_hits #(
    parameter int NCH = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] set_i,
    input  logic [NCH-1:0] clr_i,
    input  logic           load_i,
    input  logic [NCH-1:0] load_data_i,
    output logic [NCH-1:0] hit_o
);
    generate
        for (genvar c = 0; c < NCH; c++) begin : g_flag
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)      hit_o[c] <= 1'b0;
                else if (load_i) hit_o[c] <= load_data_i[c];
                else             hit_o[c] <= (hit_o[c] & ~clr_i[c]) | set_i[c];
            end
        end
    endgenerate

    a_r7_load_replaces: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> hit_o == $past(load_data_i));
    a_r6_set_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && set_i != '0) |=> ((hit_o & $past(set_i)) == $past(set_i)));
    a_r2_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && (clr_i & ~set_i) != '0) |=> ((hit_o & $past(clr_i & ~set_i)) == '0));
endmodule

// File: rtl/tok_acq_chain.sv
module tok_acq_chain #(
    parameter int NCH = 8
) (
    input  logic           tok_in_n_i,
    input  logic [NCH-1:0] hit_i,
    output logic [NCH-1:0] grant_o,
    output logic           tok_out_n_o
);
    logic [NCH:0] tok_n;

    assign tok_n[0] = tok_in_n_i;

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_link
            // a hit channel holds the token; an empty one passes it along
            assign tok_n[c+1]  = tok_n[c] | hit_i[c];
            assign grant_o[c]  = hit_i[c] & ~tok_n[c];
        end
    endgenerate

    assign tok_out_n_o = tok_n[NCH];
endmodule

// File: rtl/tok_acq_seq.sv
module tok_acq_seq
    import tok_acq_pkg::*;
#(
    parameter int NCH         = 8,
    parameter int SYNC_STAGES = 2,
    localparam int AW         = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           acq_clk_i,
    input  logic           tok_in_n_i,
    input  logic [NCH-1:0] hit_set_i,
    input  logic           hit_load_i,
    input  logic [NCH-1:0] hit_load_data_i,
    input  logic           ext_addr_sel_i,
    inout  wire  [AW-1:0]  addr_io,
    output logic           tok_out_n_o,
    output logic           ack_o,
    output logic           any_hit_o,
    output logic [AW-1:0]  sel_addr_o
);
    logic           rise_w, fall_w;
    logic [NCH-1:0] hit_w, grant_w, clr_w;
    logic [NCH-1:0] active_q;
    logic [AW-1:0]  int_addr;
    acq_state_e     state_q, state_d;

    tok_acq_edge #(.STAGES(SYNC_STAGES)) u_edge (
        .clk(clk), .rst_n(rst_n), .async_i(acq_clk_i),
        .rise_o(rise_w), .fall_o(fall_w)
    );

    tok_acq_hits #(.NCH(NCH)) u_hits (
        .clk(clk), .rst_n(rst_n), .set_i(hit_set_i), .clr_i(clr_w),
        .load_i(hit_load_i), .load_data_i(hit_load_data_i), .hit_o(hit_w)
    );

    tok_acq_chain #(.NCH(NCH)) u_chain (
        .tok_in_n_i(tok_in_n_i), .hit_i(hit_w),
        .grant_o(grant_w), .tok_out_n_o(tok_out_n_o)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (rise_w) begin
            if (grant_w != '0)    state_d = ST_SERVE;
            else if (hit_w != '0) state_d = ST_PEND;
            else                  state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:   if (hit_w != '0) state_d = ST_PEND;
                ST_PEND:   if (hit_w == '0) state_d = ST_IDLE;
                ST_SERVE:  if (fall_w)      state_d = ST_RETIRE;
                ST_RETIRE: state_d = ST_RETIRE;
            endcase
        end
    end

    // state register and active channel
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            active_q <= '0;
        end else begin
            state_q <= state_d;
            if (rise_w) active_q <= grant_w;
        end
    end

    // outputs
    always_comb begin
        clr_w     = (fall_w && state_q == ST_SERVE) ? active_q : '0;
        any_hit_o = |hit_w;
        ack_o     = (state_q != ST_IDLE) | any_hit_o;
        if (active_q != '0) int_addr = AW'(lowest_set(64'(active_q), NCH));
        else                int_addr = AW'(lowest_set(64'(hit_w), NCH));
        sel_addr_o = ext_addr_sel_i ? addr_io : int_addr;
    end

    assign addr_io = ext_addr_sel_i ? {AW{1'bz}} : int_addr;

    a_r1_single_active: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(active_q));
    a_r1_active_had_hit: assert property (@(posedge clk) disable iff (!rst_n)
        rise_w |=> ((active_q & ~$past(hit_w)) == '0));
    a_r10_token_high_no_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_w && tok_in_n_i) |=> active_q == '0);
    a_r3_token_low_means_empty: assert property (@(posedge clk) disable iff (!rst_n)
        !tok_out_n_o |-> (hit_w == '0 && !tok_in_n_i));
    a_r4_ack_low_means_done: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_o |-> (active_q == '0 && !any_hit_o));
    a_r2_serve_has_active: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SERVE || state_q == ST_RETIRE) |-> active_q != '0);
endmodule

// File: tb/tok_acq_seq_bench.sv
module tok_acq_seq_bench;
    localparam int NCH = 8;
    localparam int AW  = 3;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           acq_clk = 1'b0;
    logic           tok_in_n = 1'b0;
    logic [NCH-1:0] hit_set = '0;
    logic           hit_load = 1'b0;
    logic [NCH-1:0] load_data = '0;
    logic           ext_sel = 1'b0;
    logic [AW-1:0]  ext_drv = '0;
    wire  [AW-1:0]  addr_w;
    logic           tok_out_n, ack, any_hit;
    logic [AW-1:0]  sel_addr;

    int checks = 0;
    int fails  = 0;
    logic [NCH-1:0] m_hit = '0;
    logic [NCH-1:0] m_act = '0;
    bit done = 0;

    assign addr_w = ext_sel ? ext_drv : {AW{1'bz}};

    always #5 clk = ~clk;

    tok_acq_seq #(.NCH(NCH)) u_tok_acq_seq (
        .clk(clk), .rst_n(rst_n), .acq_clk_i(acq_clk), .tok_in_n_i(tok_in_n),
        .hit_set_i(hit_set), .hit_load_i(hit_load), .hit_load_data_i(load_data),
        .ext_addr_sel_i(ext_sel), .addr_io(addr_w), .tok_out_n_o(tok_out_n),
        .ack_o(ack), .any_hit_o(any_hit), .sel_addr_o(sel_addr)
    );

    function automatic logic [NCH-1:0] f_grant(logic [NCH-1:0] h, logic t);
        if (t) return '0;
        for (int i = 0; i < NCH; i++) if (h[i]) return NCH'(1) << i;
        return '0;
    endfunction

    function automatic logic [AW-1:0] f_low(logic [NCH-1:0] v);
        for (int i = 0; i < NCH; i++) if (v[i]) return AW'(i);
        return '0;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (8) @(negedge clk);
    endtask

    task automatic check_all();
        logic [AW-1:0] ea;
        ea = (m_act != '0) ? f_low(m_act) : f_low(m_hit);
        chk("R3 token out", 32'(tok_out_n), 32'(tok_in_n | (|m_hit)));
        chk("R4 ack", 32'(ack), 32'((|m_hit) | (|m_act)));
        chk("R5 any hit", 32'(any_hit), 32'(|m_hit));
        if (ext_sel) begin
            chk("R9 external address", 32'(sel_addr), 32'(ext_drv));
        end else begin
            chk("R8 address lines", 32'(addr_w), 32'(ea));
            chk("R8 selected address", 32'(sel_addr), 32'(ea));
        end
    endtask

    task automatic acq_edge();
        @(negedge clk);
        acq_clk = ~acq_clk;
        if (acq_clk) m_act = f_grant(m_hit, tok_in_n);  // R1 / R10
        else         m_hit = m_hit & ~m_act;             // R2
        settle();
        check_all();
    endtask

    task automatic set_pulse(logic [NCH-1:0] m);
        @(negedge clk);
        hit_set = m;
        @(negedge clk);
        hit_set = '0;
        m_hit = m_hit | m;  // R6
        settle();
        check_all();
    endtask

    task automatic load(logic [NCH-1:0] m);
        @(negedge clk);
        hit_load = 1'b1;
        load_data = m;
        hit_set = ~m;  // R7: load overrides set
        @(negedge clk);
        hit_load = 1'b0;
        hit_set = '0;
        m_hit = m;
        settle();
        check_all();
    endtask

    task automatic drain();
        for (int k = 0; k < 40 && (m_hit != '0 || m_act != '0); k++) acq_edge();
        if (acq_clk) acq_edge();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        settle();
        // R11 reset state
        chk("R11 reset ack", 32'(ack), 0);
        chk("R11 reset any hit", 32'(any_hit), 0);
        chk("R11 reset token", 32'(tok_out_n), 32'(tok_in_n));
        chk("R11 reset address", 32'(addr_w), 0);

        // R1 lone hit on the top channel
        set_pulse(8'h80);
        acq_edge();
        chk("R1 active top", 32'(addr_w), 7);
        acq_edge();
        chk("R3 token released", 32'(tok_out_n), 0);
        chk("R4 ack held to rise", 32'(ack), 1);
        acq_edge();
        chk("R4 ack dropped", 32'(ack), 0);
        acq_edge();

        // adjacent hits walk in order
        set_pulse(8'h0E);
        drain();
        chk("R1 chain drained", 32'(any_hit), 0);

        // R10 token high during a rise
        set_pulse(8'h24);
        @(negedge clk); tok_in_n = 1'b1; settle(); check_all();
        acq_edge();
        chk("R10 no active", 32'(addr_w), 2);
        chk("R10 flags kept", 32'(any_hit), 1);
        acq_edge();
        chk("R10 flags after fall", 32'(any_hit), 1);
        @(negedge clk); tok_in_n = 1'b0; settle(); check_all();

        // R6 set on active channel in the falling-edge cycle
        acq_edge();
        chk("R1 serve ch2", 32'(addr_w), 2);
        @(negedge clk);
        acq_clk = 1'b0;
        repeat (SYNC_WAIT) @(negedge clk);
        hit_set = 8'h04;
        @(negedge clk);
        hit_set = '0;
        m_hit = m_hit | 8'h04;  // set wins
        settle();
        check_all();
        chk("R6 set beats clear", 32'(any_hit), 1);

        // R7 load mid readout
        load(8'h00);
        acq_edge();
        check_all();
        acq_edge();

        // R9 external address
        @(negedge clk); ext_sel = 1'b1; ext_drv = 3'd5; settle(); check_all();
        @(negedge clk); ext_sel = 1'b0; settle(); check_all();

        // random mix
        for (int it = 0; it < 400; it++) begin
            int op;
            op = int'($urandom_range(0, 9));
            if (op < 5) acq_edge();
            else if (op < 7) set_pulse(NCH'($urandom));
            else if (op == 7) load(NCH'($urandom));
            else if (op == 8) begin
                @(negedge clk); tok_in_n = ($urandom_range(0, 3) == 0); settle(); check_all();
            end else begin
                @(negedge clk); ext_sel = $urandom_range(0, 1) != 0; ext_drv = AW'($urandom);
                settle(); check_all();
            end
        end
        done = 1;
    end

    localparam int SYNC_WAIT = 2;  // sync stages; edge detect fires in the next cycle

    initial begin
        void'($urandom(32'd2024));
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                fails++;
                checks++;
                $display("FAIL watchdog actual=timeout expected=finish");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule